// File: doc/BRIEF.md
# MDIO Management Serial Master

This block is the host side of the two-wire PHY management bus. It runs complete read and write transactions against up to 32 external PHYs, each with 32 registers of 16 bits. A CPU-facing register port has two registers. The data register holds the value to send in a write and receives the result of a read. A write to the control register names the target PHY, the target register and the direction, and it launches the transaction at once.

The block divides the system clock to make the management clock MDC, which idles low. It shifts out the frame one bit per MDC period and changes MDIO only while MDC is low. It enables its MDIO driver only for the bits it owns and samples the bus on MDC rising edges. The divider's half-period is a parameter, and its default keeps MDC at or below 2.5 MHz from a 100 MHz system clock. A read in which no PHY pulls the turnaround low is flagged as unanswered and returns all ones. Status shows busy while the frame runs and a sticky done once it has finished.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 slots of MDIO driven to 1. These are followed by the start pattern 0 then 1, all driven by the master.
- R2: The next slot pair carries the opcode: 1,0 for a read and 0,1 for a write. After it come the 5-bit PHY address and then the 5-bit register address, each most significant bit first. The control register write supplies these fields: csr_wdata[4:0] is the register address, csr_wdata[9:5] is the PHY address, and csr_wdata[10] is 1 for write and 0 for read.
- R3: In a write, the master drives the turnaround as 1 then 0. It then drives the 16 bits of the data register, most significant bit first.
- R4: In a read, mdio_oe is 0 from the first turnaround slot to the end of the frame. The 16 data bits are sampled on MDC rising edges, MSB first, and are loaded into the data register (rd_data) when the frame ends.
- R5: In a read, if the second turnaround bit is sampled as 1, no_resp is set and rd_data becomes 16'hFFFF. A later transaction that starts clears no_resp.
- R6: MDC has a period of 2*HALF_DIV system clocks while busy and is low whenever the block is idle. mdio_out and mdio_oe do not change while MDC is high.
- R7: busy rises in the cycle after the control register write. It stays high for exactly 65*2*HALF_DIV cycles. done is 0 while busy and 1 after the frame ends.
- R8: While busy, writes to either register are ignored. They neither change rd_data nor queue a second transaction.
- R9: After reset, busy, done, no_resp, mdc and mdio_oe are 0, and rd_data is 0.
- R10: A 65th idle slot follows the data field. It gives exactly one more MDC pulse with mdio_oe at 0, so a frame has 65 MDC rising edges in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | Register select: 0 control, 1 data |
| csr_wdata | input | 16 | Register write value |
| rd_data | output | 16 | Data register contents |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Last transaction complete |
| no_resp | output | 1 | Last read got no PHY response |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO driver enable |
| mdio_in | input | 1 | MDIO sampled value |

## Verification
The checker watches, on every cycle, that MDC and the MDIO driver are quiet when idle and that the outgoing bit and enable hold steady through each MDC high phase. It also checks that rd_data is frozen while busy, that done is set when busy drops, and that an unanswered read leaves all ones. The bench's scenarios are needed for the frame content itself: the preamble, opcode and address order, the turnaround patterns and the write data bits. They also show the read round trip through a behavioural PHY, the exact slot and cycle counts, and that writes issued mid-frame start nothing afterwards.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int SLOTS      = FRAME_BITS + 1;
  localparam int IDX_W      = 7;
  localparam int TA2_SLOT   = 47;
  localparam int DATA_SLOT  = 48;
  localparam int TA1_SLOT   = 46;

  typedef enum logic [1:0] {
    OPC_READ  = 2'b10,
    OPC_WRITE = 2'b01
  } mdio_opc_e;

  typedef struct packed {
    logic       is_write;
    logic [4:0] phy;
    logic [4:0] regad;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic          wrap;

  assign wrap     = run && (cnt_q == LAST);
  assign rise_stb = wrap && !ph_q;
  assign fall_stb = wrap && ph_q;
  assign mdc      = ph_q;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!run) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      ph_d  = !ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic [15:0] wdata,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_in,
  output logic        active,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic        end_stb,
  output logic [15:0] rx_data,
  output logic        rx_bad
);
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic                  act_q, act_d;
  logic                  wr_q, wr_d;
  logic [15:0]           rx_q, rx_d;
  logic                  bad_q, bad_d;
  logic [1:0]            opc, ta;
  logic [IDX_W-1:0]      own_lim;

  assign opc = cmd.is_write ? OPC_WRITE : OPC_READ;
  assign ta  = cmd.is_write ? 2'b10 : 2'b11;

  assign own_lim  = wr_q ? IDX_W'(FRAME_BITS) : IDX_W'(TA1_SLOT);
  assign mdio_oe  = act_q && (idx_q < own_lim);
  assign mdio_out = mdio_oe && sr_q[FRAME_BITS-1];
  assign end_stb  = act_q && fall_stb && (idx_q == IDX_W'(SLOTS - 1));
  assign active   = act_q;
  assign rx_data  = rx_q;
  assign rx_bad   = bad_q;

  always_comb begin
    sr_d  = sr_q;
    idx_d = idx_q;
    act_d = act_q;
    wr_d  = wr_q;
    rx_d  = rx_q;
    bad_d = bad_q;
    if (start && !act_q) begin
      sr_d  = {32'hFFFF_FFFF, 2'b01, opc, cmd.phy, cmd.regad, ta,
               cmd.is_write ? wdata : 16'h0000};
      idx_d = '0;
      act_d = 1'b1;
      wr_d  = cmd.is_write;
      rx_d  = '0;
      bad_d = 1'b0;
    end else if (act_q) begin
      if (rise_stb && !wr_q) begin
        if (idx_q == IDX_W'(TA2_SLOT)) begin
          bad_d = mdio_in;
        end
        if (idx_q >= IDX_W'(DATA_SLOT) && idx_q < IDX_W'(FRAME_BITS)) begin
          rx_d = {rx_q[14:0], mdio_in};
        end
      end
      if (fall_stb) begin
        sr_d = {sr_q[FRAME_BITS-2:0], 1'b0};
        if (idx_q == IDX_W'(SLOTS - 1)) begin
          act_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      rx_q  <= '0;
      bad_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      idx_q <= idx_d;
      act_q <= act_d;
      wr_q  <= wr_d;
      rx_q  <= rx_d;
      bad_q <= bad_d;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic        csr_sel,
  input  logic [15:0] csr_wdata,
  output logic [15:0] rd_data,
  output logic        busy,
  output logic        done,
  output logic        no_resp,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic        act;
  logic        rise_stb, fall_stb, end_stb;
  logic        start;
  logic [15:0] rx_data;
  logic        rx_bad;
  logic        cmd_wr_q;
  mdio_cmd_t   cmd;

  logic [15:0] data_q, data_d;
  logic        done_q, done_d;
  logic        nr_q, nr_d;

  assign cmd.is_write = csr_wdata[10];
  assign cmd.phy      = csr_wdata[9:5];
  assign cmd.regad    = csr_wdata[4:0];
  assign start        = csr_we && !csr_sel && !act;

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) clkgen_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (act),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame frame_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd      (cmd),
    .wdata    (data_q),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_in  (mdio_in),
    .active   (act),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .end_stb  (end_stb),
    .rx_data  (rx_data),
    .rx_bad   (rx_bad)
  );

  always_comb begin
    data_d = data_q;
    done_d = done_q;
    nr_d   = nr_q;
    if (start) begin
      done_d = 1'b0;
      nr_d   = 1'b0;
    end else if (csr_we && csr_sel && !act) begin
      data_d = csr_wdata;
    end
    if (end_stb) begin
      done_d = 1'b1;
      if (!cmd_wr_q) begin
        nr_d   = rx_bad;
        data_d = rx_bad ? 16'hFFFF : rx_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      done_q   <= 1'b0;
      nr_q     <= 1'b0;
      cmd_wr_q <= 1'b0;
    end else begin
      data_q <= data_d;
      done_q <= done_d;
      nr_q   <= nr_d;
      if (start) begin
        cmd_wr_q <= cmd.is_write;
      end
    end
  end

  assign rd_data = data_q;
  assign busy    = act;
  assign done    = done_q;
  assign no_resp = nr_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rd_data,
  input logic        busy,
  input logic        done,
  input logic        no_resp,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe
);
  // R6
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R4
  oe_idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  // R6
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  done_clear_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R5
  noresp_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_resp && !busy) |-> (rd_data == 16'hFFFF));

  // R8
  data_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(rd_data));
endmodule

bind mdio_master mdio_master_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_data  (rd_data),
  .busy     (busy),
  .done     (done),
  .no_resp  (no_resp),
  .mdc      (mdc),
  .mdio_out (mdio_out),
  .mdio_oe  (mdio_oe)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int NSLOT      = 65;

  logic        clk, rst_n;
  logic        csr_we, csr_sel;
  logic [15:0] csr_wdata;
  logic [15:0] rd_data;
  logic        busy, done, no_resp, mdc, mdio_out, mdio_oe;
  logic        mdio_in;

  int n_chk = 0;
  int n_bad = 0;

  logic        rec_v  [0:79];
  logic        rec_oe [0:79];
  int          rec_cnt = 0;
  logic [15:0] phy_mem [0:31][0:31];
  logic        phy_here = 1'b1;
  logic [9:0]  rd_addr;

  mdio_master #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .rd_data(rd_data), .busy(busy), .done(done),
    .no_resp(no_resp), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .mdio_in(mdio_in)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural PHY: record each rising edge, drive after falling edge
  always @(posedge mdc) begin
    if (rec_cnt < 80) begin
      rec_v[rec_cnt]  = mdio_out;
      rec_oe[rec_cnt] = mdio_oe;
    end
    rec_cnt = rec_cnt + 1;
  end

  always @(negedge mdc) begin
    int k;
    k = rec_cnt;
    if (k == 46) begin
      for (int i = 0; i < 10; i++) rd_addr[9-i] = rec_v[36+i];
    end
    if (!phy_here || k < 47 || k > 63) mdio_in = 1'b1;
    else if (k == 47) mdio_in = 1'b0;
    else mdio_in = phy_mem[rd_addr[9:5]][rd_addr[4:0]][63-k];
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic csr_write(input logic sel, input logic [15:0] val);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = val;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  // returns cycles busy was high
  task automatic run_txn(input logic is_wr, input logic [4:0] phy,
                         input logic [4:0] ra, output int cyc);
    rec_cnt = 0;
    csr_write(1'b0, {5'd0, is_wr, phy, ra});
    cyc = 1;
    while (busy) begin
      @(negedge clk);
      if (busy) cyc++;
    end
  endtask

  task automatic check_frame(input string req, input logic is_wr,
                             input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] d);
    logic [64:0] f;
    int bad_v, bad_oe;
    f = {32'hFFFF_FFFF, 2'b01, is_wr ? 2'b01 : 2'b10, phy, ra,
         is_wr ? 2'b10 : 2'b00, is_wr ? d : 16'h0, 1'b0};
    bad_v = 0; bad_oe = 0;
    for (int k = 0; k < NSLOT; k++) begin
      logic eoe;
      eoe = is_wr ? (k < 64) : (k < 46);
      if (rec_oe[k] !== eoe) bad_oe++;
      if (eoe && rec_v[k] !== f[64-k]) bad_v++;
    end
    check(req, "mismatched frame bits", bad_v, 0);
    check(req, "mismatched oe slots", bad_oe, 0);
    check("R10", "rising edges per frame", rec_cnt, NSLOT);
  endtask

  task automatic t_reset();
    check("R9", "busy", busy, 0);
    check("R9", "done", done, 0);
    check("R9", "no_resp", no_resp, 0);
    check("R9", "mdc", mdc, 0);
    check("R9", "oe", mdio_oe, 0);
    check("R9", "rd_data", rd_data, 0);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] d);
    int cyc;
    csr_write(1'b1, d);
    run_txn(1'b1, phy, ra, cyc);
    check_frame("R3", 1'b1, phy, ra, d);
    check("R7", "busy cycles", cyc, NSLOT*2*HALF);
    check("R7", "done", done, 1);
    if (phy_here) begin
      logic [15:0] w;
      for (int i = 0; i < 16; i++) w[15-i] = rec_v[48+i];
      phy_mem[phy][ra] = w;
    end
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] ra,
                        input logic [15:0] exp);
    int cyc;
    run_txn(1'b0, phy, ra, cyc);
    check_frame("R2", 1'b0, phy, ra, 16'h0);
    check("R4", "read data", rd_data, exp);
    check("R5", "no_resp clear", no_resp, 0);
  endtask

  task automatic t_noresp();
    int cyc;
    phy_here = 1'b0;
    run_txn(1'b0, 5'd9, 5'd3, cyc);
    check("R5", "no_resp", no_resp, 1);
    check("R5", "ones", rd_data, 16'hFFFF);
    phy_here = 1'b1;
  endtask

  task automatic t_clock();
    realtime t0, t1;
    int per;
    rec_cnt = 0;
    csr_write(1'b0, {5'd0, 1'b0, 5'd1, 5'd1});
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    per = int'((t1 - t0) / CLK_PERIOD);
    check("R6", "mdc period", per, 2*HALF);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R6", "mdc idle", mdc, 0);
  endtask

  task automatic t_busy_ignore();
    int cyc;
    rec_cnt = 0;
    csr_write(1'b0, {5'd0, 1'b0, 5'd4, 5'd7});
    repeat (20) @(negedge clk);
    csr_write(1'b1, 16'hDEAD);
    csr_write(1'b0, {5'd0, 1'b1, 5'd2, 5'd2});
    while (busy) @(negedge clk);
    check("R8", "rd_data after ignored writes", rd_data, phy_mem[4][7]);
    repeat (2*HALF*4) @(negedge clk);
    check("R8", "no queued transaction", busy, 0);
    check("R8", "edges", rec_cnt, NSLOT);
    check("R8", "phy 2 reg 2 untouched", phy_mem[2][2], 16'h0000);
  endtask

  initial begin
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++) phy_mem[p][r] = 16'h0000;
    phy_mem[4][7] = 16'h5A3C;
    csr_we = 0; csr_sel = 0; csr_wdata = 0; mdio_in = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write(5'h15, 5'h0A, 16'hA5C3);   // R1 preamble/start, R3 write
    t_read(5'h15, 5'h0A, 16'hA5C3);    // R4 round trip
    t_write(5'h1F, 5'h1F, 16'h8001);
    t_read(5'h1F, 5'h1F, 16'h8001);
    t_read(5'h00, 5'h00, 16'h0000);
    t_noresp();
    t_read(5'h04, 5'h07, 16'h5A3C);    // R5 flag cleared by new start
    t_clock();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule